// File: doc/BRIEF.md
# Virtual Timer Control and Status Register

This block pairs a down-counting timer value with a small control and status register and turns the two into a level interrupt. Software loads the timer value through a two-entry register port, then sets an enable bit and an optional mask bit in the control word. The timer value drops by one on every pulse of the counter tick input, whatever the control bits hold. It is read as a signed two's-complement number and wraps freely. The timer condition holds whenever that signed value is zero or negative.

The control word shows three live bits. Bit 0 is the enable bit and bit 1 is the mask bit, and both can be written. Bit 2 is a read-only status flag that reports the timer condition while the block is enabled and reads 0 while it is disabled. The mask has no effect on the status flag. It only keeps the condition off the interrupt pin. The interrupt output is registered, so it follows the control and count state one clock later. Clearing the enable bit silences the output, but the count keeps running and stays visible through the value register.

Top module: `vtimer_ctl`

## Requirements
- R1: With `reg_sel`=0 the read data shows enable at bit 0, mask at bit 1 and status at bit 2, and every bit from 3 upward reads 0.
- R2: A write with `reg_sel`=0 updates only enable (from bit 0 of the write data) and mask (from bit 1). Bit 2 and all upper bits of the write data have no effect, and the timer value is untouched.
- R3: While enable is 1, the status bit equals 1 exactly when the timer value, taken as signed, is less than or equal to zero. The mask bit does not change it.
- R4: While enable is 0, the status bit reads 0 for every timer value.
- R5: `timer_irq` is 1 in the cycle after an edge exactly when, just before that edge, enable was 1, mask was 0 and the timer condition held.
- R6: Each clock with `cnt_tick`=1 and no value write lowers the timer value by one, modulo 2^DATA_W (0 becomes all ones). Without a tick the value holds.
- R7: The timer value keeps counting down while enable is 0.
- R8: A write with `reg_sel`=1 loads the write data into the timer value. It takes priority over a tick in the same cycle and leaves enable and mask unchanged.
- R9: After reset, enable, mask, the timer value and `timer_irq` are all 0.
- R10: With `reg_sel`=1 the read data is the current timer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Counter tick; the timer value drops by one on each tick |
| reg_sel | input | 1 | Register select: 0 control word, 1 timer value |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| timer_irq | output | 1 | Level interrupt output |

## Verification
The hardest situations to reach from the ports are the boundaries of the signed comparison: the step from the most negative value to the largest positive value, the step from zero to all ones, and a tick in the same cycle as a reload. The bench uses an 8-bit configuration. It loads every one of the 256 values under all four enable and mask combinations and compares the status bit and the interrupt with a signed comparison computed in the bench. It then walks the counter across both wrap points with ticks, and drives a tick and a value write in the same cycle.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_MASK_BIT = 1;
  localparam int unsigned CTL_STAT_BIT = 2;
  localparam int unsigned CTL_LIVE     = 3;

  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_VALUE = 1'b1
  } vtc_sel_e;

  typedef struct packed {
    logic mask;
    logic en;
  } vtc_ctl_t;
endpackage

// File: rtl/vtc_down_counter.sv
module vtc_down_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tick,
  output logic [DATA_W-1:0] count,
  output logic              expired
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] count_d;
  logic              count_ce;

  // load wins over tick
  always_comb begin
    count_ce = load | tick;
    if (load) begin
      count_d = load_val;
    end else begin
      count_d = count_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_ce) begin
      count_q <= count_d;
    end
  end

  // signed value <= 0: sign bit set, or all zero
  assign expired = count_q[DATA_W-1] | (count_q == '0);
  assign count   = count_q;
endmodule

// File: rtl/vtc_ctl_fields.sv
module vtc_ctl_fields
  import vtc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  vtc_ctl_t wr_val,
  output vtc_ctl_t ctl
);
  vtc_ctl_t ctl_q;
  vtc_ctl_t ctl_d;

  always_comb begin
    ctl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr) begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/vtc_irq_gen.sv
module vtc_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic mask,
  input  logic cond,
  output logic status,
  output logic irq
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    status = en & cond;
    irq_d  = status & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/vtimer_ctl.sv
module vtimer_ctl
  import vtc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              timer_irq
);
  localparam int unsigned PAD_W = DATA_W - CTL_LIVE;

  vtc_sel_e          sel;
  logic              wr_ctl;
  logic              wr_val;
  vtc_ctl_t          ctl_wr;
  vtc_ctl_t          ctl_q;
  logic [DATA_W-1:0] count_q;
  logic              expired;
  logic              status;
  logic [DATA_W-1:0] ctl_word;

  always_comb begin
    sel         = vtc_sel_e'(reg_sel);
    wr_ctl      = reg_wr & (sel == SEL_CTRL);
    wr_val      = reg_wr & (sel == SEL_VALUE);
    ctl_wr.en   = reg_wdata[CTL_EN_BIT];
    ctl_wr.mask = reg_wdata[CTL_MASK_BIT];
  end

  vtc_down_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_val),
    .load_val (reg_wdata),
    .tick     (cnt_tick),
    .count    (count_q),
    .expired  (expired)
  );

  vtc_ctl_fields u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_ctl),
    .wr_val (ctl_wr),
    .ctl    (ctl_q)
  );

  vtc_irq_gen u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ctl_q.en),
    .mask   (ctl_q.mask),
    .cond   (expired),
    .status (status),
    .irq    (timer_irq)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign ctl_word[DATA_W-1:CTL_LIVE] = '0;
    end
  endgenerate
  assign ctl_word[CTL_EN_BIT]   = ctl_q.en;
  assign ctl_word[CTL_MASK_BIT] = ctl_q.mask;
  assign ctl_word[CTL_STAT_BIT] = status;

  always_comb begin
    if (sel == SEL_VALUE) begin
      reg_rdata = count_q;
    end else begin
      reg_rdata = ctl_word;
    end
  end
endmodule

// File: rtl/vtc_checker.sv
module vtc_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_tick,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              timer_irq,
  input logic [DATA_W-1:0] count,
  input logic              en,
  input logic              mask,
  input logic              cond
);
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |-> $past(en && !mask && cond));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask) |-> !timer_irq);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !(reg_wr && reg_sel)) |=> (count == $past(count) - DATA_W'(1)));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !(reg_wr && reg_sel)) |=> $stable(count));

  assert_ctl_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[DATA_W-1:3] == '0));

  assert_status_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_sel && !en) |-> !reg_rdata[2]);

  assert_value_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata == count));
endmodule

bind vtimer_ctl vtc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_tick  (cnt_tick),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .timer_irq (timer_irq),
  .count     (count_q),
  .en        (ctl_q.en),
  .mask      (ctl_q.mask),
  .cond      (expired)
);

// File: tb/vtimer_ctl_test.sv
module vtimer_ctl_test;
  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         cnt_tick;
  logic         reg_sel;
  logic         reg_wr;
  logic [W-1:0] reg_wdata;
  logic [W-1:0] reg_rdata;
  logic         timer_irq;

  int tests;
  int fails;
  bit done;

  // bench model
  logic [W-1:0] m_cnt;
  logic         m_en;
  logic         m_mk;
  logic         m_irq;

  vtimer_ctl #(.DATA_W(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_tick  (cnt_tick),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .timer_irq (timer_irq)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic bit cond_of(input logic [W-1:0] v);
    int s;
    s = (int'(v) >= (1 << (W-1))) ? int'(v) - (1 << W) : int'(v);
    return s <= 0;
  endfunction

  function automatic logic [W-1:0] ctl_exp();
    logic [W-1:0] r;
    r = '0;
    r[0] = m_en;
    r[1] = m_mk;
    r[2] = m_en & cond_of(m_cnt);
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model follows edge, returns at next negedge
  task automatic step(input logic tk, input logic sel, input logic we, input logic [W-1:0] d);
    cnt_tick  = tk;
    reg_sel   = sel;
    reg_wr    = we;
    reg_wdata = d;
    @(posedge clk);
    m_irq = m_en & ~m_mk & cond_of(m_cnt);
    if (we && sel) m_cnt = d;
    else if (tk)   m_cnt = m_cnt - 1'b1;
    if (we && !sel) begin
      m_en = d[0];
      m_mk = d[1];
    end
    @(negedge clk);
    cnt_tick = 1'b0;
    reg_wr   = 1'b0;
  endtask

  task automatic peek(input logic sel, output logic [W-1:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [W-1:0] v;
    peek(1'b0, v);
    chk(req, v, ctl_exp());
    peek(1'b1, v);
    chk(req, v, m_cnt);
    chk(req, {{(W-1){1'b0}}, timer_irq}, {{(W-1){1'b0}}, m_irq});
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    tests = 0; fails = 0; done = 0;
    cnt_tick = 0; reg_sel = 0; reg_wr = 0; reg_wdata = '0;
    m_cnt = '0; m_en = 0; m_mk = 0; m_irq = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check_all("R9");
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, '0);
    check_all("R9");

    // R3 R4 R5 R1: every value under every enable/mask pair
    for (int val = 0; val < (1 << W); val++) begin
      for (int em = 0; em < 4; em++) begin
        step(1'b0, 1'b1, 1'b1, W'(val));
        step(1'b0, 1'b0, 1'b1, W'(em));
        peek(1'b0, v);
        chk("R3/R4/R1 status sweep", v, ctl_exp());
        step(1'b0, 1'b0, 1'b0, '0);
        chk("R5 irq sweep", {{(W-1){1'b0}}, timer_irq}, {{(W-1){1'b0}}, m_irq});
      end
    end

    // R2: upper and status bits of control write ignored, value untouched
    step(1'b0, 1'b1, 1'b1, 8'h05);
    step(1'b0, 1'b0, 1'b1, 8'hFC);
    check_all("R2 upper bits ignored");
    step(1'b0, 1'b0, 1'b1, 8'hFD);
    check_all("R2 enable only");

    // R6 R3 R5: tick down across zero and the all-ones wrap
    step(1'b0, 1'b0, 1'b1, 8'h01);
    step(1'b0, 1'b1, 1'b1, 8'h03);
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0, 1'b0, '0);
      check_all("R6 tick down through zero");
    end

    // R6: most negative to largest positive wrap drops the condition
    step(1'b0, 1'b1, 1'b1, 8'h81);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 1'b0, '0);
      check_all("R6 signed wrap");
    end

    // R7: counting continues while disabled
    step(1'b0, 1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b1, 1'b1, 8'h10);
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b0, 1'b0, '0);
      check_all("R7 count while disabled");
    end
    step(1'b0, 1'b0, 1'b1, 8'h01);
    step(1'b0, 1'b0, 1'b0, '0);
    check_all("R7 enable after disabled count");

    // R8: load beats tick, control unchanged
    step(1'b1, 1'b1, 1'b1, 8'h40);
    check_all("R8 load over tick");
    peek(1'b1, v);
    chk("R8 loaded value", v, 8'h40);
    step(1'b1, 1'b0, 1'b1, 8'h03);
    check_all("R8 control write with tick");
    step(1'b1, 1'b0, 1'b0, '0);
    check_all("R10 value read");

    // R9: reset mid-run
    rst_n = 1'b0;
    m_cnt = '0; m_en = 0; m_mk = 0; m_irq = 0;
    #1;
    check_all("R9 async reset");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule